// File: doc/BRIEF.md
# Descriptor-Ring Transmit DMA Channel

This block is the transmit half of a packet DMA engine. Software builds a ring of 64-bit descriptors in memory. Each descriptor names a buffer, gives its length and carries ownership and framing flags. Software then sets the channel enable bit. The channel fetches the descriptor at its current ring position. If software owns the descriptor to the channel, the channel reads the buffer in bounded bursts and sends it byte by byte on a valid/ready stream toward a MAC, marking the first and last byte of each frame. It then writes the descriptor's control word back with the ownership bit cleared and moves on to the next ring slot.

The channel keeps running until it reaches a descriptor that it does not own. At that point it raises a no-descriptor status, drops its enable bit and waits. Software queues more frames and writes the enable bit again. A per-frame request to append a CRC travels alongside the stream; the CRC itself is computed downstream. Status events are write-one-to-clear and are combined with a mask onto one interrupt line. A bit in a reset register shared between channels aborts the channel and returns it to the ring base.

Top module: `txdma_chan`

## Requirements
- R1: After reset, every register reads 0 except the burst register, which reads 8. The ring position is 0. `irq_o`, `tx_valid_o` and `mem_req_o` are low. Register word addresses: 0 config (bit 0 enable), 1 status, 2 interrupt mask, 3 burst, 4 ring base, 5 channel reset.
- R2: A descriptor is one 64-bit memory word. The low 32 bits are the control word: length in bits 27:16, owned in bit 15, end-of-frame in bit 14, start-of-frame in bit 13, ring-last in bit 12, CRC request in bit 8. The high 32 bits are the buffer address, which must be 8-byte aligned. Buffer bytes are streamed in ascending address order, with byte k of a 64-bit word taken from bits 8k+7:8k.
- R3: `tx_sop_o` marks the first byte of a start-of-frame descriptor, and `tx_last_o` marks the final byte of an end-of-frame descriptor. Descriptors in between are joined into one frame. While `tx_ready_i` is low, the data and flags are held.
- R4: `tx_crc_o` is loaded from bit 8 of each start-of-frame descriptor. It stays constant for every byte of that frame, and descriptors that do not start a frame leave it unchanged.
- R5: After the last byte of a descriptor is accepted, the channel writes to the descriptor address with byte enables 0x0F. The written control word has the owned bit cleared and all other bits unchanged.
- R6: After a ring-last descriptor, the next fetch goes to the ring base. After any other descriptor, the next fetch goes to the current address plus 8. Writing the ring base register also moves the ring position to the new base.
- R7: Writing 1 to enable starts fetching at the current ring position. The channel then processes owned descriptors back to back without further writes.
- R8: On fetching a descriptor it does not own, the channel sets status bit 2, clears enable, writes nothing back and goes idle. Its ring position stays on that descriptor.
- R9: Status bit 0 sets after every write-back. Status bit 1 sets after the write-back of an end-of-frame descriptor. Writing 1 to a status bit clears it. `irq_o` is the OR of status bits ANDed with the mask.
- R10: Buffer reads come in groups of at most the burst value in 64-bit words, with 0 treated as 1 and values above BUF_WORDS (16) treated as 16. No group is read until the previous group has been fully streamed.
- R11: Writing the reset register with bit CH_IDX*2+1 set (bit 1 by default) aborts the channel, clears enable and returns the ring position to the ring base. Bit CH_IDX*2, the receive subchannel, has no effect on this channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational from address) |
| irq_o | output | 1 | Masked status interrupt |
| mem_req_o | output | 1 | Memory request, held until granted |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Byte address, 8-byte aligned |
| mem_be_o | output | 8 | Write byte enables |
| mem_wdata_o | output | 64 | Write data |
| mem_gnt_i | input | 1 | Request accepted this cycle |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Read data |
| tx_data_o | output | 8 | Stream byte |
| tx_valid_o | output | 1 | Stream byte valid |
| tx_ready_i | input | 1 | Stream sink ready |
| tx_sop_o | output | 1 | First byte of frame |
| tx_last_o | output | 1 | Last byte of frame |
| tx_crc_o | output | 1 | Append-CRC request for the current frame |

## Verification
The bench targets several corner cases, each paired with how a faulty design would show it:
- A frame split over two descriptors: a design that marks each descriptor as its own frame would emit an extra start or end marker.
- A ring-last descriptor: a design that ignores wrap would fetch beyond the ring.
- Burst limits of 0, 2 and an over-range value: an unclamped design would overrun its buffer or issue more reads between streamed bytes than allowed.
- A stalled stream aborted through the shared reset register: the bench checks that the receive bit leaves the channel untouched, and that the transmit bit sends the next fetch back to the ring base rather than the stalled slot.

// File: rtl/txdma_pkg.sv
package txdma_pkg;

  typedef struct packed {
    logic [3:0]  rsv_hi;
    logic [11:0] len;
    logic        own;
    logic        eop;
    logic        sop;
    logic        wrap;
    logic [2:0]  rsv_mid;
    logic        crc;
    logic [7:0]  rsv_lo;
  } dctl_t;

  localparam logic [2:0] REG_CFG   = 3'd0;
  localparam logic [2:0] REG_STAT  = 3'd1;
  localparam logic [2:0] REG_MASK  = 3'd2;
  localparam logic [2:0] REG_BURST = 3'd3;
  localparam logic [2:0] REG_BASE  = 3'd4;
  localparam logic [2:0] REG_RST   = 3'd5;

  localparam int EV_BUF    = 0;
  localparam int EV_PKT    = 1;
  localparam int EV_NODESC = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DREQ, ST_DWAIT, ST_BREQ, ST_BWAIT, ST_DRAIN, ST_WB
  } st_e;

endpackage

// File: rtl/txdma_regs.sv
module txdma_regs
  import txdma_pkg::*;
#(
  parameter int BUF_WORDS = 16,
  parameter int CH_IDX    = 0,
  localparam int BL_W     = $clog2(BUF_WORDS + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic [2:0]      reg_addr_i,
  input  logic [31:0]     reg_wdata_i,
  output logic [31:0]     reg_rdata_o,
  input  logic            ev_buf_done_i,
  input  logic            ev_pkt_done_i,
  input  logic            ev_no_desc_i,
  output logic            en_o,
  output logic [BL_W-1:0] burst_lim_o,
  output logic [31:0]     ring_base_o,
  output logic            pos_load_o,
  output logic            abort_o,
  output logic            irq_o
);
  localparam int RST_BIT = CH_IDX * 2 + 1;

  logic        en_q, pos_load_q, abort_q;
  logic [2:0]  stat_q, mask_q, ev;
  logic [7:0]  burst_q;
  logic [31:0] base_q;
  logic        wr_cfg, wr_stat, wr_rst;

  assign ev      = {ev_no_desc_i, ev_pkt_done_i, ev_buf_done_i};
  assign wr_cfg  = reg_we_i && reg_addr_i == REG_CFG;
  assign wr_stat = reg_we_i && reg_addr_i == REG_STAT;
  assign wr_rst  = reg_we_i && reg_addr_i == REG_RST && reg_wdata_i[RST_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= 1'b0;
      stat_q     <= '0;
      mask_q     <= '0;
      burst_q    <= 8'd8;
      base_q     <= '0;
      pos_load_q <= 1'b0;
      abort_q    <= 1'b0;
    end else begin
      pos_load_q <= 1'b0;
      abort_q    <= 1'b0;
      if (ev_no_desc_i) en_q <= 1'b0;
      if (wr_cfg) en_q <= reg_wdata_i[0];
      // new events win over a simultaneous clear
      stat_q <= (stat_q & ~(wr_stat ? reg_wdata_i[2:0] : 3'b000)) | ev;
      if (reg_we_i && reg_addr_i == REG_MASK)  mask_q  <= reg_wdata_i[2:0];
      if (reg_we_i && reg_addr_i == REG_BURST) burst_q <= reg_wdata_i[7:0];
      if (reg_we_i && reg_addr_i == REG_BASE) begin
        base_q     <= {reg_wdata_i[31:3], 3'b000};
        pos_load_q <= 1'b1;
      end
      if (wr_rst) begin
        en_q    <= 1'b0;
        abort_q <= 1'b1;
      end
    end
  end

  always_comb begin
    if (burst_q == 8'd0)                   burst_lim_o = BL_W'(1);
    else if (32'(burst_q) > BUF_WORDS)     burst_lim_o = BL_W'(BUF_WORDS);
    else                                   burst_lim_o = BL_W'(burst_q);
  end

  always_comb begin
    case (reg_addr_i)
      REG_CFG:   reg_rdata_o = {31'd0, en_q};
      REG_STAT:  reg_rdata_o = {29'd0, stat_q};
      REG_MASK:  reg_rdata_o = {29'd0, mask_q};
      REG_BURST: reg_rdata_o = {24'd0, burst_q};
      REG_BASE:  reg_rdata_o = base_q;
      default:   reg_rdata_o = '0;
    endcase
  end

  assign en_o        = en_q;
  assign ring_base_o = base_q;
  assign pos_load_o  = pos_load_q;
  assign abort_o     = abort_q;
  assign irq_o       = |(stat_q & mask_q);

  assert_nodesc_clears_en_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_no_desc_i && !wr_cfg) |=> !en_o);

  assert_w1c_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && reg_wdata_i[EV_PKT] && !ev_pkt_done_i) |=> !reg_stat_pkt());

  function automatic logic reg_stat_pkt();
    return stat_q[EV_PKT];
  endfunction

endmodule

// File: rtl/txdma_wbuf.sv
module txdma_wbuf #(
  parameter int DEPTH = 16,
  parameter int W     = 64,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  head_o,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= (32'(wp_q) == DEPTH - 1) ? '0 : wp_q + PW'(1);
      if (pop_i)  rp_q <= (32'(rp_q) == DEPTH - 1) ? '0 : rp_q + PW'(1);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= data_i;
  end

  assign head_o  = mem_q[rp_q];
  assign count_o = cnt_q;

  assert_no_overflow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> 32'(cnt_q) < DEPTH);

  assert_no_underflow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> cnt_q != '0);

endmodule

// File: rtl/txdma_ctrl.sv
module txdma_ctrl
  import txdma_pkg::*;
#(
  parameter int BUF_WORDS = 16,
  localparam int BL_W     = $clog2(BUF_WORDS + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [BL_W-1:0] burst_lim_i,
  input  logic [31:0]     ring_base_i,
  input  logic            pos_load_i,
  input  logic            abort_i,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [31:0]     mem_addr_o,
  output logic [7:0]      mem_be_o,
  output logic [63:0]     mem_wdata_o,
  input  logic            mem_gnt_i,
  input  logic            mem_rvalid_i,
  input  logic [63:0]     mem_rdata_i,
  output logic [7:0]      tx_data_o,
  output logic            tx_valid_o,
  input  logic            tx_ready_i,
  output logic            tx_sop_o,
  output logic            tx_last_o,
  output logic            tx_crc_o,
  output logic            ev_buf_done_o,
  output logic            ev_pkt_done_o,
  output logic            ev_no_desc_o,
  output logic            push_o,
  output logic            pop_o,
  output logic            clr_o,
  input  logic [63:0]     head_i,
  input  logic [BL_W-1:0] count_i
);
  st_e         st_q;
  dctl_t       ctl_q, rd_ctl, wb_ctl;
  logic [31:0] cur_ptr_q, buf_ptr_q, rd_ptr_q;
  logic [11:0] bytes_left_q;
  logic [9:0]  words_left_q;
  logic [12:0] words_calc;
  logic [BL_W-1:0] burst_cnt_q;
  logic [2:0]  byte_idx_q;
  logic        sop_pend_q, crc_q;
  logic        fire, word_end, last_byte;

  assign rd_ctl     = dctl_t'(mem_rdata_i[31:0]);
  assign words_calc = ({1'b0, rd_ctl.len} + 13'd7) >> 3;

  always_comb begin
    wb_ctl     = ctl_q;
    wb_ctl.own = 1'b0;
  end

  assign mem_req_o   = st_q inside {ST_DREQ, ST_BREQ, ST_WB};
  assign mem_we_o    = st_q == ST_WB;
  assign mem_addr_o  = (st_q == ST_BREQ) ? rd_ptr_q : cur_ptr_q;
  assign mem_be_o    = (st_q == ST_WB) ? 8'h0F : 8'hFF;
  assign mem_wdata_o = {buf_ptr_q, wb_ctl};

  assign tx_valid_o = st_q == ST_DRAIN;
  assign tx_data_o  = head_i[{byte_idx_q, 3'b000} +: 8];
  assign last_byte  = bytes_left_q == 12'd1;
  assign tx_sop_o   = tx_valid_o && sop_pend_q;
  assign tx_last_o  = tx_valid_o && last_byte && ctl_q.eop;
  assign tx_crc_o   = crc_q;

  assign fire     = tx_valid_o && tx_ready_i;
  assign word_end = byte_idx_q == 3'd7 || last_byte;
  assign pop_o    = fire && word_end;
  assign push_o   = st_q == ST_BWAIT && mem_rvalid_i;
  assign clr_o    = abort_i;

  assign ev_no_desc_o  = st_q == ST_DWAIT && mem_rvalid_i && !rd_ctl.own;
  assign ev_buf_done_o = st_q == ST_WB && mem_gnt_i;
  assign ev_pkt_done_o = ev_buf_done_o && ctl_q.eop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      ctl_q        <= '0;
      cur_ptr_q    <= '0;
      buf_ptr_q    <= '0;
      rd_ptr_q     <= '0;
      bytes_left_q <= '0;
      words_left_q <= '0;
      burst_cnt_q  <= '0;
      byte_idx_q   <= '0;
      sop_pend_q   <= 1'b0;
      crc_q        <= 1'b0;
    end else if (abort_i) begin
      st_q       <= ST_IDLE;
      cur_ptr_q  <= ring_base_i;
      sop_pend_q <= 1'b0;
    end else begin
      if (pos_load_i) cur_ptr_q <= ring_base_i;
      unique case (st_q)
        ST_IDLE: if (en_i) st_q <= ST_DREQ;
        ST_DREQ: if (mem_gnt_i) st_q <= ST_DWAIT;
        ST_DWAIT: if (mem_rvalid_i) begin
          if (!rd_ctl.own) begin
            st_q <= ST_IDLE;
          end else begin
            ctl_q        <= rd_ctl;
            buf_ptr_q    <= mem_rdata_i[63:32];
            rd_ptr_q     <= {mem_rdata_i[63:35], 3'b000};
            bytes_left_q <= rd_ctl.len;
            words_left_q <= words_calc[9:0];
            burst_cnt_q  <= '0;
            byte_idx_q   <= '0;
            if (rd_ctl.sop) begin
              sop_pend_q <= 1'b1;
              crc_q      <= rd_ctl.crc;
            end
            st_q <= (rd_ctl.len == 12'd0) ? ST_WB : ST_BREQ;
          end
        end
        ST_BREQ: if (mem_gnt_i) st_q <= ST_BWAIT;
        ST_BWAIT: if (mem_rvalid_i) begin
          rd_ptr_q     <= rd_ptr_q + 32'd8;
          words_left_q <= words_left_q - 10'd1;
          burst_cnt_q  <= burst_cnt_q + BL_W'(1);
          if (words_left_q == 10'd1 || (burst_cnt_q + BL_W'(1)) >= burst_lim_i)
            st_q <= ST_DRAIN;
          else
            st_q <= ST_BREQ;
        end
        ST_DRAIN: if (fire) begin
          bytes_left_q <= bytes_left_q - 12'd1;
          sop_pend_q   <= 1'b0;
          byte_idx_q   <= word_end ? 3'd0 : byte_idx_q + 3'd1;
          if (last_byte) begin
            st_q <= ST_WB;
          end else if (word_end && count_i == BL_W'(1)) begin
            st_q        <= ST_BREQ;
            burst_cnt_q <= '0;
          end
        end
        ST_WB: if (mem_gnt_i) begin
          cur_ptr_q <= ctl_q.wrap ? ring_base_i : cur_ptr_q + 32'd8;
          st_q      <= en_i ? ST_DREQ : ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assert_stream_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i && !abort_i) |=>
      (tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o) && $stable(tx_sop_o)));

  assert_last_then_gap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_last_o && tx_ready_i) |=> !tx_valid_o);

  assert_crc_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_sop_o) |-> $stable(tx_crc_o));

  assert_nodesc_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_no_desc_o |=> !mem_req_o && !tx_valid_o);

  assert_burst_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> count_i < burst_lim_i);

endmodule

// File: rtl/txdma_chan.sv
module txdma_chan
  import txdma_pkg::*;
#(
  parameter int BUF_WORDS = 16,
  parameter int CH_IDX    = 0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        irq_o,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [31:0] mem_addr_o,
  output logic [7:0]  mem_be_o,
  output logic [63:0] mem_wdata_o,
  input  logic        mem_gnt_i,
  input  logic        mem_rvalid_i,
  input  logic [63:0] mem_rdata_i,
  output logic [7:0]  tx_data_o,
  output logic        tx_valid_o,
  input  logic        tx_ready_i,
  output logic        tx_sop_o,
  output logic        tx_last_o,
  output logic        tx_crc_o
);
  localparam int BL_W = $clog2(BUF_WORDS + 1);

  logic            en, pos_load, abort;
  logic [BL_W-1:0] burst_lim, count;
  logic [31:0]     ring_base;
  logic            ev_buf, ev_pkt, ev_nodesc;
  logic            push, pop, clr;
  logic [63:0]     head;

  txdma_regs #(.BUF_WORDS(BUF_WORDS), .CH_IDX(CH_IDX)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .ev_buf_done_i(ev_buf), .ev_pkt_done_i(ev_pkt), .ev_no_desc_i(ev_nodesc),
    .en_o(en), .burst_lim_o(burst_lim), .ring_base_o(ring_base),
    .pos_load_o(pos_load), .abort_o(abort), .irq_o
  );

  txdma_wbuf #(.DEPTH(BUF_WORDS), .W(64)) u_wbuf (
    .clk_i, .rst_ni, .clr_i(clr), .push_i(push), .data_i(mem_rdata_i),
    .pop_i(pop), .head_o(head), .count_o(count)
  );

  txdma_ctrl #(.BUF_WORDS(BUF_WORDS)) u_ctrl (
    .clk_i, .rst_ni, .en_i(en), .burst_lim_i(burst_lim), .ring_base_i(ring_base),
    .pos_load_i(pos_load), .abort_i(abort),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_be_o, .mem_wdata_o,
    .mem_gnt_i, .mem_rvalid_i, .mem_rdata_i,
    .tx_data_o, .tx_valid_o, .tx_ready_i, .tx_sop_o, .tx_last_o, .tx_crc_o,
    .ev_buf_done_o(ev_buf), .ev_pkt_done_o(ev_pkt), .ev_no_desc_o(ev_nodesc),
    .push_o(push), .pop_o(pop), .clr_o(clr), .head_i(head), .count_i(count)
  );

endmodule

// File: tb/tb_txdma_chan.sv
`timescale 1ns/1ps
module tb_txdma_chan;
  localparam logic [2:0] A_CFG = 3'd0, A_STAT = 3'd1, A_MASK = 3'd2,
                         A_BURST = 3'd3, A_BASE = 3'd4, A_RST = 3'd5;
  localparam int RING = 32'h100;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        irq, mem_req, mem_we, mem_gnt = 1'b1, mem_rvalid = 1'b0;
  logic [31:0] mem_addr;
  logic [7:0]  mem_be, tx_data;
  logic [63:0] mem_wdata, mem_rdata = '0;
  logic        tx_valid, tx_ready = 1'b1, tx_sop, tx_last, tx_crc;

  txdma_chan dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wdata), .mem_gnt_i(mem_gnt), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .tx_data_o(tx_data), .tx_valid_o(tx_valid),
    .tx_ready_i(tx_ready), .tx_sop_o(tx_sop), .tx_last_o(tx_last), .tx_crc_o(tx_crc)
  );

  int checks = 0, fails = 0;
  logic [63:0] mem [128];
  logic        host_we = 1'b0;
  logic [6:0]  host_idx = '0;
  logic [63:0] host_data = '0;
  logic [7:0]  cap_data [1024];
  logic        cap_sop [1024], cap_last [1024], cap_crc [1024];
  int          cap_run [1024];
  int          cap_n = 0, run = 0, ready_limit = 1 << 30;
  logic [31:0] last_desc = '0;
  int          cyc = 0;

  function automatic logic [7:0] bval(int a);
    return 8'(a * 7 + 3);
  endfunction

  function automatic logic [63:0] pword(logic [31:0] a);
    logic [63:0] w;
    for (int k = 0; k < 8; k++) w[8*k +: 8] = bval(int'(a) + k);
    return w;
  endfunction

  // memory model and stream monitor
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) mem[i] <= '0;
      mem_rvalid <= 1'b0;
    end else begin
      mem_rvalid <= 1'b0;
      if (mem_req && mem_gnt) begin
        if (mem_we) begin
          for (int k = 0; k < 8; k++)
            if (mem_be[k] && mem_addr < 32'h400) mem[mem_addr[9:3]][8*k +: 8] <= mem_wdata[8*k +: 8];
        end else begin
          mem_rvalid <= 1'b1;
          if (mem_addr < 32'h400) begin
            mem_rdata <= mem[mem_addr[9:3]];
            last_desc <= mem_addr;
          end else begin
            mem_rdata <= pword(mem_addr);
            run <= run + 1;
          end
        end
      end
      if (host_we) mem[host_idx] <= host_data;
      if (tx_valid && tx_ready) begin
        cap_data[cap_n] <= tx_data;
        cap_sop[cap_n]  <= tx_sop;
        cap_last[cap_n] <= tx_last;
        cap_crc[cap_n]  <= tx_crc;
        cap_run[cap_n]  <= run;
        cap_n <= cap_n + 1;
        run <= 0;
      end
    end
  end

  initial forever begin
    @(negedge clk);
    mem_gnt  <= (cyc % 4) != 3;
    tx_ready <= cap_n < ready_limit;
  end

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic put_desc(int addr, logic [31:0] ctl, logic [31:0] buf_a);
    @(negedge clk); host_we = 1'b1; host_idx = 7'(addr >> 3); host_data = {buf_a, ctl};
    @(negedge clk); host_we = 1'b0;
  endtask

  function automatic logic [31:0] mk(int len, bit sop, bit eop, bit wrap, bit crc);
    return {4'd0, 12'(len), 1'b1, eop, sop, wrap, 3'd0, crc, 8'd0};
  endfunction

  task automatic prep(logic [7:0] burst);
    reg_wr(A_STAT, 32'h7);
    for (int i = 32; i < 40; i++) put_desc(i * 8, 32'd0, 32'd0);
    reg_wr(A_BASE, RING);
    reg_wr(A_BURST, {24'd0, burst});
  endtask

  task automatic run_wait();
    logic [31:0] v;
    reg_wr(A_CFG, 32'h1);
    for (int i = 0; i < 4000; i++) begin
      reg_rd(A_CFG, v);
      if (!v[0]) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic chk_seg(int pos, int buf_a, int len, bit sop, bit eop, bit crc, string req);
    int bad = 0; longint act = 0, exp = 0;
    for (int i = 0; i < len; i++) begin
      logic [10:0] g, e;
      g = {cap_data[pos+i], cap_sop[pos+i], cap_last[pos+i], cap_crc[pos+i]};
      e = {bval(buf_a + i), sop && i == 0, eop && i == len - 1, crc};
      if (g !== e && bad == 0) begin act = longint'(g); exp = longint'(e); end
      if (g !== e) bad++;
    end
    chk(bad == 0, req, act, exp);
  endtask

  function automatic int max_run(int pos, int len);
    int m = 0;
    for (int i = pos; i < pos + len; i++) if (cap_run[i] > m) m = cap_run[i];
    return m;
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    reg_rd(A_CFG, v);   chk(v == 0, "R1 cfg", v, 0);
    reg_rd(A_STAT, v);  chk(v == 0, "R1 stat", v, 0);
    reg_rd(A_MASK, v);  chk(v == 0, "R1 mask", v, 0);
    reg_rd(A_BURST, v); chk(v == 8, "R1 burst", v, 8);
    reg_rd(A_BASE, v);  chk(v == 0, "R1 base", v, 0);
    chk({irq, tx_valid, mem_req} == 3'b000, "R1 outputs", {irq, tx_valid, mem_req}, 0);
  endtask

  task automatic t_single();
    logic [31:0] v; int s;
    prep(8'd8);
    put_desc(RING, mk(13, 1, 1, 0, 1), 32'h400);
    s = cap_n;
    run_wait();
    chk(cap_n - s == 13, "R7 byte count", cap_n - s, 13);
    chk_seg(s, 32'h400, 13, 1, 1, 1, "R2 R3 R4 single frame");
    chk(mem[RING >> 3] == {32'h400, mk(13, 1, 1, 0, 1) & ~32'h8000}, "R5 writeback",
        mem[RING >> 3][31:0], mk(13, 1, 1, 0, 1) & ~32'h8000);
    reg_rd(A_STAT, v); chk(v == 7, "R9 R8 status", v, 7);
    chk(last_desc == RING + 8, "R8 stop slot", last_desc, RING + 8);
    chk(mem[(RING >> 3) + 1] == 0, "R8 no writeback", mem[(RING >> 3) + 1], 0);
  endtask

  task automatic t_multi();
    logic [31:0] v; int s;
    prep(8'd8);
    reg_wr(A_MASK, 32'h2);
    chk(irq == 1'b0, "R9 irq idle", irq, 0);
    put_desc(RING,      mk(10, 1, 0, 0, 0), 32'h400);
    put_desc(RING + 8,  mk(7, 0, 1, 0, 1),  32'h440);
    put_desc(RING + 16, mk(9, 1, 1, 1, 1),  32'h480);
    put_desc(RING + 24, mk(5, 1, 1, 0, 1),  32'h4C0);
    s = cap_n;
    run_wait();
    chk(cap_n - s == 26, "R7 multi count", cap_n - s, 26);
    chk_seg(s, 32'h400, 10, 1, 0, 0, "R3 R4 frame A part 1");
    chk_seg(s + 10, 32'h440, 7, 0, 1, 0, "R3 R4 frame A part 2");
    chk_seg(s + 17, 32'h480, 9, 1, 1, 1, "R3 R4 frame B");
    chk(last_desc == RING, "R6 wrap to base", last_desc, RING);
    chk(mem[(RING >> 3) + 3][15] == 1'b1, "R6 slot after wrap untouched", 0, 1);
    chk(irq == 1'b1, "R9 irq set", irq, 1);
    reg_wr(A_STAT, 32'h2);
    reg_rd(A_STAT, v); chk(v == 5, "R9 w1c", v, 5);
    chk(irq == 1'b0, "R9 irq cleared", irq, 0);
    reg_wr(A_MASK, 32'h0);
  endtask

  task automatic t_burst(logic [7:0] b, int len, int exp_run);
    int s;
    prep(b);
    put_desc(RING, mk(len, 1, 1, 0, 0), 32'h500);
    s = cap_n;
    run_wait();
    chk_seg(s, 32'h500, len, 1, 1, 0, "R10 burst data");
    chk(max_run(s, len) == exp_run, "R10 reads per group", max_run(s, len), exp_run);
  endtask

  task automatic t_chan_reset();
    logic [31:0] v; logic [7:0] d0; int s;
    prep(8'd8);
    put_desc(RING,     mk(5, 1, 1, 0, 0),  32'h400);
    put_desc(RING + 8, mk(64, 1, 1, 0, 1), 32'h500);
    s = cap_n;
    ready_limit = s + 8;
    reg_wr(A_CFG, 32'h1);
    repeat (80) @(negedge clk);
    chk(cap_n == s + 8 && tx_valid, "R3 stalled stream", cap_n - s, 8);
    d0 = tx_data;
    repeat (3) @(negedge clk);
    chk(tx_data == d0 && tx_data == bval(32'h503), "R3 hold", tx_data, bval(32'h503));
    reg_wr(A_RST, 32'h1);
    repeat (3) @(negedge clk);
    reg_rd(A_CFG, v);
    chk(v[0] && tx_valid, "R11 rx bit ignored", {v[0], tx_valid}, 3);
    chk(last_desc == RING + 8, "R11 position kept", last_desc, RING + 8);
    reg_wr(A_RST, 32'h2);
    repeat (3) @(negedge clk);
    reg_rd(A_CFG, v);
    chk(!v[0] && !tx_valid, "R11 abort", {v[0], tx_valid}, 0);
    ready_limit = 1 << 30;
    reg_wr(A_STAT, 32'h7);
    run_wait();
    chk(last_desc == RING, "R11 back to base", last_desc, RING);
    reg_rd(A_STAT, v); chk(v == 4, "R8 R11 nodesc at base", v, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_single();
    t_multi();
    t_burst(8'd2, 40, 2);
    t_burst(8'd8, 40, 5);
    t_burst(8'd0, 40, 1);
    t_burst(8'd31, 160, 16);
    t_chan_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all requirements act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule